// File: doc/BRIEF.md
# Serial ADC Sample Reader

This block is an SPI master that fetches one conversion at a time from a serial single-channel ADC and hands back a right-aligned unsigned result. A one-cycle trigger starts a read. If the conversion-start option is on, the block first drives an active-low conversion-start line for a short pulse. It then waits out the worst-case conversion time before it opens the SPI frame. If the option is off, the frame opens on the next clock. Every read is a fixed 16-clock frame with chip select low throughout. The bits come in most-significant first.

The ADC families place the result at different positions inside the 16-bit word. A two-bit alignment select and a two-bit resolution select pick the right shift and the width mask. Both are latched when a read starts. Some parts need an 8-clock dummy frame to reset them. The block sends this frame once after its own reset when the alignment select names such a part. It sends it again whenever the reset request input is pulsed while idle. The data received in a dummy frame is thrown away. A trigger that arrives while the block is busy is dropped and reported on an overrun strobe. The result stays steady between valid strobes.

Top module: `adc_sample_reader`

## Requirements
- R1: While `rst_n` is low: `cs_n` is 1, `sclk` is 0, `cnvst_n` is 0, `sample_valid` is 0 and `sample` is 0.
- R2: A read frame holds `cs_n` low for exactly 16 rising edges of `sclk`. `sclk` rests low whenever `cs_n` is high. With the default sampling edge, `miso` is captured just before each rising edge, and the first bit captured is frame bit 15.
- R3: The result is `(frame >> s) & (2^n - 1)`, where n = 8, 10, 12 or 14 for `res_sel` = 0, 1, 2 or 3. The shift is s = max(0, b - n), with b = 12, 13, 15 or 16 for `align_sel` = 0, 1, 2 or 3.
- R4: With `cnv_en` = 1, `cnvst_n` is low for PW_CYC = ceil(PULSE_NS·CLK_HZ/1e9) cycles after the trigger. It then goes high and stays high for CONV_CYC = ceil(CONV_NS·CLK_HZ/1e9) cycles before `cs_n` falls. With the defaults these are 1 and 65 cycles.
- R5: With `cnv_en` = 0, `cs_n` falls on the clock edge that samples the trigger, and `cnvst_n` does not change.
- R6: When reset is released with `align_sel` = 3, the block sends one 8-clock dummy frame and raises no `sample_valid`. With any other `align_sel` it sends no frame.
- R7: A `dev_rst_req` pulse while idle sends an 8-clock frame, raises no `sample_valid` and leaves `sample` unchanged. If `trig` is high in the same cycle, the trigger wins.
- R8: A trigger while `busy` is high raises `overrun` for exactly one cycle. The read in progress still completes with its own data, and no extra read follows.
- R9: `sample_valid` is high for exactly one cycle per completed read. `sample` changes only in that cycle and holds its value until the next one.
- R10: Once a conversion-start pulse has ended, `cnvst_n` stays high except during later pulses, and no pulse starts while `cs_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig | input | 1 | Start a read (one-cycle pulse) |
| dev_rst_req | input | 1 | Send the 8-clock ADC reset frame |
| cnv_en | input | 1 | Use the conversion-start pulse and wait before the frame |
| align_sel | input | 2 | Family alignment: shift base 12/13/15/16 |
| res_sel | input | 2 | Resolution: 8/10/12/14 bits |
| miso | input | 1 | Serial data from the ADC |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Chip select, active low |
| cnvst_n | output | 1 | Conversion-start, active low |
| busy | output | 1 | A read or reset frame is under way |
| overrun | output | 1 | One-cycle flag for a dropped trigger |
| sample_valid | output | 1 | One-cycle strobe: new result |
| sample | output | SAMPLE_W | Right-aligned unsigned result |

## Verification
The bench targets the shift saturation case: 14 bits with the 12-bit base. A design that computed a negative shift would return a wrapped or empty field. It also drives frame words with patterns at both ends, so that a shift off by one or a mask one bit too wide shows up as a wrong result. The pulse and conversion-wait lengths are counted cycle by cycle, which catches a divider that rounds down or a frame that opens during the wait. It also checks the dummy frames and the triggers that land mid-frame: a design that restarted on them, raised a valid for dummy data, or counted the wrong number of clocks would show a wrong frame length, an extra strobe or a changed result.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

   typedef enum logic [2:0] {
      ST_INIT,
      ST_IDLE,
      ST_PULSE,
      ST_WAIT,
      ST_XFER
   } rd_state_e;

   localparam int NUM_RES = 4;

   // resolution code -> bit count (8, 10, 12, 14)
   function automatic int res_bits(input int code);
      return 8 + 2 * code;
   endfunction

   // alignment code -> shift base (12, 13, 15, 16)
   function automatic int align_base(input logic [1:0] code);
      case (code)
         2'd0:    return 12;
         2'd1:    return 13;
         2'd2:    return 15;
         default: return 16;
      endcase
   endfunction

   // round a nanosecond minimum up to whole clocks, at least one
   function automatic int ns_to_cycles(input int ns, input int clk_hz);
      longint prod;
      longint cyc;
      prod = longint'(ns) * longint'(clk_hz);
      cyc  = (prod + 64'd999_999_999) / 64'd1_000_000_000;
      if (cyc < 1) cyc = 1;
      return int'(cyc);
   endfunction

endpackage

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/adc_rd_sclk_gen.sv
module adc_rd_sclk_gen #(
   parameter int HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sclk,
   output logic rise_evt,
   output logic fall_evt
);

   localparam int PERIOD = 2 * HALF;
   localparam int PH_W   = (PERIOD > 2) ? $clog2(PERIOD) : 1;
   localparam logic [PH_W-1:0] PH_RISE = PH_W'(HALF - 1);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD - 1);
   localparam logic [PH_W-1:0] PH_HIGH = PH_W'(HALF);

   logic [PH_W-1:0] ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ph_q <= '0;
      else if (!run || ph_q == PH_LAST)
         ph_q <= '0;
      else
         ph_q <= ph_q + 1'b1;
   end

   assign sclk     = run && (ph_q >= PH_HIGH);
   assign rise_evt = run && (ph_q == PH_RISE);
   assign fall_evt = run && (ph_q == PH_LAST);

endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter #(
   parameter int FRAME_W        = 16,
   parameter bit SAMPLE_ON_RISE = 1'b1,
   parameter int LEN_W          = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               rise_evt,
   input  logic               fall_evt,
   input  logic               miso,
   input  logic [LEN_W-1:0]   len,
   output logic               done,
   output logic [FRAME_W-1:0] word
);

   logic [FRAME_W-1:0] sh_q;
   logic [FRAME_W-1:0] sh_d;
   logic [LEN_W-1:0]   per_q;
   logic               capture;

   generate
      if (SAMPLE_ON_RISE) begin : g_rise
         assign capture = rise_evt;
      end else begin : g_fall
         assign capture = fall_evt;
      end
   endgenerate

   always_comb begin
      sh_d = sh_q;
      if (capture)
         sh_d = {sh_q[FRAME_W-2:0], miso};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         per_q <= '0;
      end else if (!run) begin
         sh_q  <= '0;
         per_q <= '0;
      end else begin
         sh_q <= sh_d;
         if (fall_evt)
            per_q <= per_q + 1'b1;
      end
   end

   assign done = run && fall_evt && (per_q == len - 1'b1);
   assign word = sh_d;

endmodule

// File: rtl/adc_rd_extract.sv
module adc_rd_extract
   import adc_rd_pkg::*;
#(
   parameter int FRAME_W  = 16,
   parameter int SAMPLE_W = 14
) (
   input  logic [FRAME_W-1:0]  word,
   input  logic [1:0]          align_sel,
   input  logic [1:0]          res_sel,
   output logic [SAMPLE_W-1:0] value
);

   logic [SAMPLE_W-1:0] lane [NUM_RES];

   genvar r;
   generate
      for (r = 0; r < NUM_RES; r++) begin : g_res
         localparam int BITS = 8 + 2 * r;
         localparam logic [SAMPLE_W-1:0] MASK = SAMPLE_W'((64'd1 << BITS) - 64'd1);
         logic [4:0]         sh;
         logic [FRAME_W-1:0] moved;

         always_comb begin
            if (align_base(align_sel) > BITS)
               sh = 5'(align_base(align_sel) - BITS);
            else
               sh = '0;
         end

         assign moved   = word >> sh;
         assign lane[r] = SAMPLE_W'(moved) & MASK;
      end
   endgenerate

   assign value = lane[res_sel];

endmodule

// File: rtl/adc_sample_reader.sv
module adc_sample_reader
   import adc_rd_pkg::*;
#(
   parameter int CLK_HZ         = 100_000_000,
   parameter int PULSE_NS       = 10,
   parameter int CONV_NS        = 650,
   parameter int SCLK_HALF      = 2,
   parameter bit SAMPLE_ON_RISE = 1'b1,
   parameter int FRAME_W        = 16,
   parameter int RESET_BITS     = 8,
   parameter int SAMPLE_W       = 14
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                trig,
   input  logic                dev_rst_req,
   input  logic                cnv_en,
   input  logic [1:0]          align_sel,
   input  logic [1:0]          res_sel,
   input  logic                miso,
   output logic                sclk,
   output logic                cs_n,
   output logic                cnvst_n,
   output logic                busy,
   output logic                overrun,
   output logic                sample_valid,
   output logic [SAMPLE_W-1:0] sample
);

   localparam int PW_CYC   = ns_to_cycles(PULSE_NS, CLK_HZ);
   localparam int CONV_CYC = ns_to_cycles(CONV_NS, CLK_HZ);
   localparam int MAX_CYC  = (PW_CYC > CONV_CYC) ? PW_CYC : CONV_CYC;
   localparam int TMR_W    = $clog2(MAX_CYC + 1);
   localparam int LEN_W    = $clog2(FRAME_W + 1);
   localparam logic [TMR_W-1:0] PW_LOAD   = TMR_W'(PW_CYC - 1);
   localparam logic [TMR_W-1:0] CONV_LOAD = TMR_W'(CONV_CYC - 1);
   localparam logic [LEN_W-1:0] LEN_READ  = LEN_W'(FRAME_W);
   localparam logic [LEN_W-1:0] LEN_DUMMY = LEN_W'(RESET_BITS);

   initial begin : param_check
      assert (SCLK_HALF >= 1) else $error("SCLK_HALF must be at least 1");
      assert (FRAME_W >= 16) else $error("FRAME_W must hold the 16-bit frame");
      assert (SAMPLE_W >= 14) else $error("SAMPLE_W must hold 14 bits");
      assert (RESET_BITS >= 1 && RESET_BITS <= FRAME_W) else $error("RESET_BITS out of range");
      assert (CLK_HZ >= 1_000_000) else $error("CLK_HZ too small");
   end

   rd_state_e          state_q;
   logic               dummy_q;
   logic               armed_q;
   logic [1:0]         align_q;
   logic [1:0]         res_q;
   logic               ovr_q;
   logic               vld_q;
   logic [SAMPLE_W-1:0] smp_q;

   logic               tmr_load;
   logic [TMR_W-1:0]   tmr_val;
   logic               tmr_done;
   logic               run;
   logic               rise_evt;
   logic               fall_evt;
   logic               frame_done;
   logic [FRAME_W-1:0] frame_word;
   logic [SAMPLE_W-1:0] extracted;

   assign run = (state_q == ST_XFER);

   adc_rd_timer #(.CNT_W(TMR_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_done)
   );

   adc_rd_sclk_gen #(.HALF(SCLK_HALF)) u_sclk (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .sclk     (sclk),
      .rise_evt (rise_evt),
      .fall_evt (fall_evt)
   );

   adc_rd_shifter #(
      .FRAME_W        (FRAME_W),
      .SAMPLE_ON_RISE (SAMPLE_ON_RISE),
      .LEN_W          (LEN_W)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .rise_evt (rise_evt),
      .fall_evt (fall_evt),
      .miso     (miso),
      .len      (dummy_q ? LEN_DUMMY : LEN_READ),
      .done     (frame_done),
      .word     (frame_word)
   );

   adc_rd_extract #(
      .FRAME_W  (FRAME_W),
      .SAMPLE_W (SAMPLE_W)
   ) u_extract (
      .word      (frame_word),
      .align_sel (align_q),
      .res_sel   (res_q),
      .value     (extracted)
   );

   // timer loads: pulse width on trigger, conversion wait on pulse end
   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = PW_LOAD;
      if (state_q == ST_IDLE && trig && cnv_en) begin
         tmr_load = 1'b1;
         tmr_val  = PW_LOAD;
      end else if (state_q == ST_PULSE && tmr_done) begin
         tmr_load = 1'b1;
         tmr_val  = CONV_LOAD;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_INIT;
         dummy_q <= 1'b0;
         armed_q <= 1'b0;
         align_q <= '0;
         res_q   <= '0;
         ovr_q   <= 1'b0;
         vld_q   <= 1'b0;
         smp_q   <= '0;
      end else begin
         vld_q <= 1'b0;
         ovr_q <= trig && (state_q != ST_IDLE);
         case (state_q)
            ST_INIT: begin
               align_q <= align_sel;
               if (align_sel == 2'd3) begin
                  dummy_q <= 1'b1;
                  state_q <= ST_XFER;
               end else begin
                  state_q <= ST_IDLE;
               end
            end
            ST_IDLE: begin
               if (trig) begin
                  align_q <= align_sel;
                  res_q   <= res_sel;
                  dummy_q <= 1'b0;
                  state_q <= cnv_en ? ST_PULSE : ST_XFER;
               end else if (dev_rst_req) begin
                  dummy_q <= 1'b1;
                  state_q <= ST_XFER;
               end
            end
            ST_PULSE: begin
               if (tmr_done) begin
                  armed_q <= 1'b1;
                  state_q <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (tmr_done)
                  state_q <= ST_XFER;
            end
            ST_XFER: begin
               if (frame_done) begin
                  state_q <= ST_IDLE;
                  if (!dummy_q) begin
                     vld_q <= 1'b1;
                     smp_q <= extracted;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign cs_n         = !run;
   assign cnvst_n      = armed_q && (state_q != ST_PULSE);
   assign busy         = (state_q != ST_IDLE);
   assign overrun      = ovr_q;
   assign sample_valid = vld_q;
   assign sample       = smp_q;

endmodule

// File: rtl/adc_rd_checker.sv
module adc_rd_checker #(
   parameter int SAMPLE_W = 14
) (
   input logic                clk,
   input logic                rst_n,
   input logic                trig,
   input logic                busy,
   input logic                overrun,
   input logic                sclk,
   input logic                cs_n,
   input logic                cnvst_n,
   input logic                sample_valid,
   input logic [SAMPLE_W-1:0] sample
);

   AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk) else $error("sclk active outside frame"); // R2

   AST_VALID_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      sample_valid |=> !sample_valid) else $error("valid longer than one cycle"); // R9

   AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_valid |-> $stable(sample)) else $error("sample moved without valid"); // R9

   AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |-> ($past(trig) && $past(busy))) else $error("overrun without busy trigger"); // R8

   AST_OVERRUN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !trig) |=> !overrun) else $error("overrun stretched"); // R8

   AST_CNV_NOT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cnvst_n) |-> cs_n) else $error("conversion pulse during frame"); // R10

endmodule

bind adc_sample_reader adc_rd_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .trig         (trig),
   .busy         (busy),
   .overrun      (overrun),
   .sclk         (sclk),
   .cs_n         (cs_n),
   .cnvst_n      (cnvst_n),
   .sample_valid (sample_valid),
   .sample       (sample)
);

// File: tb/adc_sample_reader_test.sv
module adc_sample_reader_test;

   localparam int SW      = 14;
   localparam int PW_EXP  = 1;
   localparam int CNV_EXP = 65;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          trig = 1'b0;
   logic          dev_rst_req = 1'b0;
   logic          cnv_en = 1'b0;
   logic [1:0]    align_sel = 2'd0;
   logic [1:0]    res_sel = 2'd0;
   logic          miso = 1'b0;
   logic          sclk, cs_n, cnvst_n, busy, overrun, sample_valid;
   logic [SW-1:0] sample;

   int checks = 0;
   int errors = 0;

   logic [15:0] slave_word = 16'h0000;
   int  bit_idx = 15;
   logic cs_p = 1'b1;
   logic sclk_p = 1'b0;
   logic cnv_p = 1'b0;
   int  edges = 0;
   int  last_len = 0;
   int  frame_cnt = 0;
   int  valid_cnt = 0;
   int  cnv_falls = 0;

   adc_sample_reader uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .trig         (trig),
      .dev_rst_req  (dev_rst_req),
      .cnv_en       (cnv_en),
      .align_sel    (align_sel),
      .res_sel      (res_sel),
      .miso         (miso),
      .sclk         (sclk),
      .cs_n         (cs_n),
      .cnvst_n      (cnvst_n),
      .busy         (busy),
      .overrun      (overrun),
      .sample_valid (sample_valid),
      .sample       (sample)
   );

   always #5 clk = ~clk;

   // ADC model and frame monitor, all on the falling clock edge
   always @(negedge clk) begin
      if (!cs_n && cs_p) begin
         edges   = 0;
         bit_idx = 15;
         miso   <= slave_word[15];
      end else if (!cs_n && !sclk && sclk_p) begin
         if (bit_idx > 0) bit_idx = bit_idx - 1;
         miso <= slave_word[bit_idx];
      end
      if (!cs_n && sclk && !sclk_p) edges = edges + 1;
      if (cs_n && !cs_p) begin
         last_len  = edges;
         frame_cnt = frame_cnt + 1;
      end
      if (sample_valid) valid_cnt = valid_cnt + 1;
      if (!cnvst_n && cnv_p) cnv_falls = cnv_falls + 1;
      cs_p   = cs_n;
      sclk_p = sclk;
      cnv_p  = cnvst_n;
   end

   function automatic logic [SW-1:0] expect_val(input logic [1:0] al, input logic [1:0] rs,
                                                input logic [15:0] w);
      int bits, base, sh;
      logic [31:0] v;
      bits = 8 + 2 * int'(rs);
      case (al)
         2'd0: base = 12;
         2'd1: base = 13;
         2'd2: base = 15;
         default: base = 16;
      endcase
      sh = (base > bits) ? base - bits : 0;
      v  = (32'(w) >> sh) & ((32'd1 << bits) - 1);
      return SW'(v);
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wait_idle(input int limit);
      for (int i = 0; i < limit; i++) begin
         if (!busy) return;
         @(negedge clk);
      end
   endtask

   task automatic do_reset(input logic [1:0] al);
      @(negedge clk);
      rst_n     = 1'b0;
      align_sel = al;
      repeat (3) @(negedge clk);
      check(cs_n === 1'b1 && sclk === 1'b0 && cnvst_n === 1'b0 &&
            sample_valid === 1'b0 && sample === '0, "R1", "reset outputs",
            {cs_n, sclk, cnvst_n, sample_valid}, 4'b1000);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic do_read(input logic [1:0] al, input logic [1:0] rs,
                          input logic cnv, input logic [15:0] w, input bit detail);
      int lowc, waitc, vc0, fc0, cf0, guard;
      logic cnv_before;
      logic [SW-1:0] expv;
      wait_idle(500);
      align_sel  = al;
      res_sel    = rs;
      cnv_en     = cnv;
      slave_word = w;
      expv       = expect_val(al, rs, w);
      vc0        = valid_cnt;
      fc0        = frame_cnt;
      cf0        = cnv_falls;
      cnv_before = cnvst_n;
      trig       = 1'b1;
      @(negedge clk);
      trig = 1'b0;
      if (cnv) begin
         lowc = 0;
         waitc = 0;
         while (cnvst_n == 1'b0 && lowc < 1000) begin lowc++; @(negedge clk); end
         while (cs_n == 1'b1 && waitc < 1000) begin
            if (!cnvst_n) break;
            waitc++;
            @(negedge clk);
         end
         if (detail) begin
            check(lowc == PW_EXP, "R4", "pulse width", lowc, PW_EXP);
            check(waitc == CNV_EXP, "R4", "conversion wait", waitc, CNV_EXP);
         end
      end else if (detail) begin
         check(cs_n === 1'b0, "R5", "frame opens at once", cs_n, 0);
      end
      guard = 0;
      while (!sample_valid && guard < 2000) begin guard++; @(negedge clk); end
      check(sample === expv, "R3", "extracted sample", sample, expv);
      @(negedge clk);
      check(!sample_valid, "R9", "valid one cycle", sample_valid, 0);
      check(last_len == 16 && frame_cnt == fc0 + 1, "R2", "frame clocks", last_len, 16);
      repeat (3) @(negedge clk);
      check(sample === expv && valid_cnt == vc0 + 1, "R9", "sample held",
            sample, expv);
      if (!cnv && detail)
         check(cnvst_n === cnv_before && cnv_falls == cf0, "R5", "no conversion pulse",
               cnvst_n, cnv_before);
      if (detail)
         check(cnvst_n === (cnv ? 1'b1 : cnv_before), "R10", "cnvst rests high after pulse",
               cnvst_n, 1);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : stim
      int seed_dummy;
      int vc0, fc0;
      logic [SW-1:0] held;
      seed_dummy = $urandom(32'h1F3A);

      // R6: reset release with the 16-base family sends a dummy frame
      do_reset(2'd3);
      fc0 = frame_cnt;
      wait_idle(500);
      @(negedge clk);
      check(frame_cnt == fc0 + 1 && last_len == 8, "R6", "init dummy frame", last_len, 8);
      check(valid_cnt == 0, "R6", "no valid for dummy", valid_cnt, 0);

      // R6: other families send nothing
      do_reset(2'd0);
      fc0 = frame_cnt;
      repeat (40) @(negedge clk);
      check(frame_cnt == fc0 && cs_n === 1'b1, "R6", "no init frame", frame_cnt, fc0);

      // directed reads
      do_read(2'd0, 2'd2, 1'b0, 16'h0ABC, 1'b1);
      do_read(2'd0, 2'd3, 1'b0, 16'h3FFF, 1'b1);   // saturated shift
      do_read(2'd1, 2'd0, 1'b0, 16'h1FE0, 1'b1);
      do_read(2'd2, 2'd3, 1'b1, 16'hFFFD, 1'b1);
      do_read(2'd3, 2'd2, 1'b1, 16'h8001, 1'b1);
      do_read(2'd3, 2'd0, 1'b0, 16'hFF00, 1'b1);
      do_read(2'd1, 2'd1, 1'b1, 16'h0000, 1'b1);

      // R7: reset request sends an 8-clock frame, no valid, sample kept
      wait_idle(500);
      held = sample;
      vc0  = valid_cnt;
      fc0  = frame_cnt;
      dev_rst_req = 1'b1;
      @(negedge clk);
      dev_rst_req = 1'b0;
      wait_idle(500);
      @(negedge clk);
      check(frame_cnt == fc0 + 1 && last_len == 8, "R7", "reset frame length", last_len, 8);
      check(valid_cnt == vc0 && sample === held, "R7", "reset frame discarded", sample, held);

      // R8: trigger mid-frame is dropped and flagged
      align_sel  = 2'd2;
      res_sel    = 2'd1;
      cnv_en     = 1'b0;
      slave_word = 16'h5A5A;
      vc0        = valid_cnt;
      fc0        = frame_cnt;
      trig       = 1'b1;
      @(negedge clk);
      trig = 1'b0;
      repeat (10) @(negedge clk);
      slave_word = 16'h5A5A;
      trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
      check(overrun === 1'b1, "R8", "overrun raised", overrun, 1);
      @(negedge clk);
      check(overrun === 1'b0, "R8", "overrun one cycle", overrun, 0);
      wait_idle(500);
      repeat (20) @(negedge clk);
      check(valid_cnt == vc0 + 1 && frame_cnt == fc0 + 1, "R8", "single read done",
            valid_cnt - vc0, 1);
      check(sample === expect_val(2'd2, 2'd1, 16'h5A5A), "R8", "read kept its data",
            sample, expect_val(2'd2, 2'd1, 16'h5A5A));

      // random reads
      for (int k = 0; k < 40; k++) begin
         do_read(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                 1'($urandom_range(0, 1)), 16'($urandom), 1'b0);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule